// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous memory that serves bursts of four words. A load cycle takes a complete address from the address bus. The lowest two bits of that address become the start offset of the burst. Each later advance cycle moves the offset one beat further. The upper part of the address stays fixed for the whole burst, so every beat of a burst stays inside the same aligned four-word block.

One combined control input selects the operation: low loads, high advances. An active-low clock enable gates every sampled input. While it is high, all state stays as it is, which stretches the current cycle. A static order input chooses between two beat orders. Linear order adds the step count to the start offset, modulo four. Interleaved order XORs the step count with the start offset. Both outputs are registered: the full address and the burst offset.

Top module: `burst_addr_seq`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `addr_out` and `offset_out` are both zero, and the step count is cleared.
- R2: At an edge with `clk_en_n` = 0 and `adv_ld_n` = 0, the block captures `addr_in`. After that edge, `addr_out` equals the captured value, `offset_out` equals its two lowest bits, and the step count restarts at 0.
- R3: At an edge with `clk_en_n` = 0, `adv_ld_n` = 1 and `order_ilv` = 0 (linear), the new `offset_out` is the previous `offset_out` plus one, modulo 4.
- R4: At an edge with `clk_en_n` = 0, `adv_ld_n` = 1 and `order_ilv` = 1 (interleaved), the step count rises by one (modulo 4), and `offset_out` becomes the start offset XOR the step count. For a start of 1 the sequence is 1, 0, 3, 2.
- R5: An advance never changes `addr_out[17:2]`.
- R6: At an edge with `clk_en_n` = 1, both outputs keep their values, whatever `adv_ld_n`, `order_ilv` and `addr_in` hold.
- R7: After four advances, in either order, the offset is back at the start offset, still inside the same four-word block.
- R8: `offset_out` always equals `addr_out[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| adv_ld_n | input | 1 | 0 = load a new address, 1 = advance the burst |
| order_ilv | input | 1 | Burst order: 0 = linear, 1 = interleaved (XOR) |
| addr_in | input | 18 | Address bus captured on a load |
| addr_out | output | 18 | Current full word address (registered) |
| offset_out | output | 2 | Current burst offset (registered) |

## Verification
Every start offset from 0 to 3 is run through a full burst in both orders. This separates the linear sequence (start+step) from the interleaved one (start XOR step), because for start offsets 1 and 3 the two orders give different beats. An all-ones address shows that the offset wraps inside its block and never carries into the upper bits. A held clock enable, with a conflicting load pending on the bus, shows that the cycle is only stretched. A reload in the middle of a burst and a reset in the middle of a burst show that the step count restarts. A pseudo-random run mixes all three operations against a model written from the requirements.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } bseq_op_e;

endpackage

// File: rtl/bseq_op_decode.sv
module bseq_op_decode
  import bseq_pkg::*;
(
  input  logic     clk_en_n,
  input  logic     adv_ld_n,
  output bseq_op_e op
);

  always_comb begin
    if (clk_en_n)      op = OP_HOLD;
    else if (!adv_ld_n) op = OP_LOAD;
    else               op = OP_STEP;
  end

endmodule

// File: rtl/bseq_step_ctr.sv
module bseq_step_ctr
  import bseq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  bseq_op_e           op,
  input  logic [BURST_W-1:0] start_in,
  output logic [BURST_W-1:0] start_q,
  output logic [BURST_W-1:0] step_nxt
);

  logic [BURST_W-1:0] step_q;

  always_comb begin
    step_nxt = step_q + BURST_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= '0;
      start_q <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          step_q  <= '0;
          start_q <= start_in;
        end
        OP_STEP: step_q <= step_nxt;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map #(
  parameter int BURST_W = 2
) (
  input  logic               order_ilv,
  input  logic [BURST_W-1:0] start,
  input  logic [BURST_W-1:0] step,
  output logic [BURST_W-1:0] offset
);

  logic [BURST_W-1:0] lin_off;
  logic [BURST_W-1:0] ilv_off;
  logic [BURST_W:0]   carry;

  assign carry[0] = 1'b0;

  genvar b;
  generate
    for (b = 0; b < BURST_W; b++) begin : g_bit
      assign ilv_off[b]  = start[b] ^ step[b];
      assign lin_off[b]  = start[b] ^ step[b] ^ carry[b];
      assign carry[b+1]  = (start[b] & step[b]) | (carry[b] & (start[b] ^ step[b]));
    end
  endgenerate

  always_comb begin
    offset = order_ilv ? ilv_off : lin_off;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              adv_ld_n,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BURST_W-1:0] offset_out
);

  localparam int UPPER_W = ADDR_W - BURST_W;

  bseq_op_e           op;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] step_nxt;
  logic [BURST_W-1:0] mapped_off;
  logic [UPPER_W-1:0] base_q;

  bseq_op_decode u_dec (
    .clk_en_n (clk_en_n),
    .adv_ld_n (adv_ld_n),
    .op       (op)
  );

  bseq_step_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .start_in (addr_in[BURST_W-1:0]),
    .start_q  (start_q),
    .step_nxt (step_nxt)
  );

  bseq_order_map #(.BURST_W(BURST_W)) u_map (
    .order_ilv (order_ilv),
    .start     (start_q),
    .step      (step_nxt),
    .offset    (mapped_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      addr_out   <= '0;
      offset_out <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          base_q     <= addr_in[ADDR_W-1:BURST_W];
          addr_out   <= addr_in;
          offset_out <= addr_in[BURST_W-1:0];
        end
        OP_STEP: begin
          addr_out   <= {base_q, mapped_off};
          offset_out <= mapped_off;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               clk_en_n,
  input logic               adv_ld_n,
  input logic               order_ilv,
  input logic [ADDR_W-1:0]  addr_in,
  input logic [ADDR_W-1:0]  addr_out,
  input logic [BURST_W-1:0] offset_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && offset_out == '0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld_n) |=> (addr_out == $past(addr_in)));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && adv_ld_n && !order_ilv) |=>
      (offset_out == BURST_W'($past(offset_out) + BURST_W'(1))));

  // R4
  ilv_lsb_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && adv_ld_n && order_ilv) |=> (offset_out[0] != $past(offset_out[0])));

  // R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && adv_ld_n) |=> (addr_out[ADDR_W-1:BURST_W] == $past(addr_out[ADDR_W-1:BURST_W])));

  // R6
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(addr_out) && $stable(offset_out)));

  // R8
  offset_match_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en_n |=> (offset_out == addr_out[BURST_W-1:0]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .clk_en_n   (clk_en_n),
  .adv_ld_n   (adv_ld_n),
  .order_ilv  (order_ilv),
  .addr_in    (addr_in),
  .addr_out   (addr_out),
  .offset_out (offset_out)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

  localparam int AW = 18;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic          clk_en_n;
  logic          adv_ld_n;
  logic          order_ilv;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic [1:0]    offset_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq dut_i (
    .clk        (clk),
    .rst        (rst),
    .clk_en_n   (clk_en_n),
    .adv_ld_n   (adv_ld_n),
    .order_ilv  (order_ilv),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .offset_out (offset_out)
  );

  // {clk_en_n, adv_ld_n, order_ilv, addr_in, expected addr_out, req}
  typedef struct packed {
    logic          cen_n;
    logic          adv;
    logic          ilv;
    logic [AW-1:0] ain;
    logic [AW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 18'h12345, 18'h12345, 4'd2}, // R2 load, start 1
    '{1'b0, 1'b1, 1'b0, 18'h00000, 18'h12346, 4'd3}, // R3 linear 2
    '{1'b0, 1'b1, 1'b0, 18'h00000, 18'h12347, 4'd3}, // R3 linear 3
    '{1'b0, 1'b1, 1'b0, 18'h00000, 18'h12344, 4'd3}, // R3 linear 0
    '{1'b0, 1'b1, 1'b0, 18'h00000, 18'h12345, 4'd7}, // R7 back to start
    '{1'b1, 1'b0, 1'b1, 18'h3FFFF, 18'h12345, 4'd6}, // R6 load masked
    '{1'b0, 1'b0, 1'b1, 18'h2ABCD, 18'h2ABCD, 4'd2}, // R2 load, start 1
    '{1'b0, 1'b1, 1'b1, 18'h00000, 18'h2ABCC, 4'd4}, // R4 1^1=0
    '{1'b0, 1'b1, 1'b1, 18'h00000, 18'h2ABCF, 4'd4}, // R4 1^2=3
    '{1'b0, 1'b1, 1'b1, 18'h00000, 18'h2ABCE, 4'd4}, // R4 1^3=2
    '{1'b0, 1'b1, 1'b1, 18'h00000, 18'h2ABCD, 4'd7}, // R7 interleaved wrap
    '{1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h3FFFF, 4'd2}, // R2 all ones
    '{1'b0, 1'b1, 1'b0, 18'h00000, 18'h3FFFC, 4'd5}, // R5 no carry upward
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h3FFFC, 4'd6}, // R6 advance masked
    '{1'b0, 1'b1, 1'b0, 18'h00000, 18'h3FFFD, 4'd3}, // R3 resumes
    '{1'b0, 1'b0, 1'b1, 18'h00002, 18'h00002, 4'd2}, // R2 start 2
    '{1'b0, 1'b1, 1'b1, 18'h00000, 18'h00003, 4'd4}, // R4 2^1=3
    '{1'b0, 1'b1, 1'b1, 18'h00000, 18'h00000, 4'd4}, // R4 2^2=0
    '{1'b0, 1'b0, 1'b1, 18'h1F0F3, 18'h1F0F3, 4'd2}, // R2 reload mid-burst
    '{1'b0, 1'b1, 1'b1, 18'h00000, 18'h1F0F2, 4'd4}  // R4 step restarted, 3^1=2
  };

  task automatic check(input string tag, input logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s addr_out actual=%05h expected=%05h", tag, addr_out, exp);
    end
    checks++;
    if (offset_out !== exp[1:0]) begin
      errors++;
      $display("FAIL %s/R8 offset_out actual=%0d expected=%0d", tag, offset_out, exp[1:0]);
    end
  endtask

  task automatic cycle(input logic c, input logic a, input logic m, input logic [AW-1:0] d);
    clk_en_n  = c;
    adv_ld_n  = a;
    order_ilv = m;
    addr_in   = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0]   lfsr;
    logic [AW-3:0] m_base;
    logic [1:0]    m_start;
    logic [1:0]    m_step;
    logic [AW-1:0] m_exp;
    logic          m_ilv;

    rst = 1'b1; clk_en_n = 1'b1; adv_ld_n = 1'b1; order_ilv = 1'b0; addr_in = '0;
    @(negedge clk);
    cycle(1'b1, 1'b1, 1'b0, '0);
    check("R1 reset state", '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i].cen_n, VEC[i].adv, VEC[i].ilv, VEC[i].ain);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
    end

    // R1: reset mid-burst clears address and step count
    cycle(1'b0, 1'b0, 1'b0, 18'h25556);
    cycle(1'b0, 1'b1, 1'b0, '0);
    rst = 1'b1;
    cycle(1'b0, 1'b1, 1'b0, '0);
    check("R1 reset mid-burst", '0);
    rst = 1'b0;
    cycle(1'b0, 1'b1, 1'b1, '0);
    check("R1 step cleared (0^1)", 18'h00001);

    // R7: every start offset, both orders, four beats return to start
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 2; o++) begin
        logic [AW-1:0] a0;
        a0 = {16'hC3A5, 2'(s)};
        cycle(1'b0, 1'b0, 1'(o), a0);
        for (int k = 1; k <= 4; k++) begin
          logic [1:0] e;
          cycle(1'b0, 1'b1, 1'(o), '0);
          e = (o == 1) ? (2'(s) ^ 2'(k)) : 2'(s + k);
          check(o == 1 ? "R4/R7 sweep" : "R3/R7 sweep", {16'hC3A5, e});
        end
      end
    end

    // Mixed pseudo-random run against a model from the requirements
    lfsr = 16'hACE1;
    m_base = 16'hC3A5; m_start = 2'd3; m_step = 2'd0; m_exp = {16'hC3A5, 2'd3};
    m_ilv = 1'b1;
    cycle(1'b0, 1'b0, m_ilv, m_exp);
    for (int n = 0; n < 300; n++) begin
      logic c, a;
      logic [AW-1:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c = (lfsr[2:0] == 3'd0);
      a = (lfsr[5:3] != 3'd0);
      d = {lfsr[15:0], lfsr[7:6]} ^ 18'(n * 7);
      if (!c && !a) m_ilv = lfsr[9];
      cycle(c, a, m_ilv, d);
      if (!c) begin
        if (!a) begin
          m_base = d[AW-1:2]; m_start = d[1:0]; m_step = 2'd0; m_exp = d;
        end else begin
          m_step = m_step + 2'd1;
          m_exp  = {m_base, m_ilv ? (m_start ^ m_step) : (m_start + m_step)};
        end
      end
      check(c ? "R6 random" : (a ? (m_ilv ? "R4 random" : "R3 random") : "R2 random"), m_exp);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule